// File: doc/BRIEF.md
# Chip-Select Memory Timing Controller

This block turns one internal access request into the chip-select, output-enable and per-byte write-strobe waveforms for a single external memory bank. A request carries an address, a read/write flag and byte enables. A set of option inputs shapes the access:

- an address-to-select setup delay;
- early negation of the strobes and select on writes;
- a relaxed mode that stretches both the setup and the wait time;
- a wait-state count;
- a choice between ending the access from the internal counter or from an external acknowledge.

Every access ends with a single-cycle data-valid pulse, followed by one recovery cycle.

The request side is a valid/ready stream. `req_ready` is high only while the block is idle. A request transfers on the rising edge where both `req_valid` and `req_ready` are high. The requester may hold `req_valid` for as long as it likes; nothing is taken while `req_ready` is low, so back-pressure lasts for the whole access. All option inputs, the address, the direction and the byte enables are captured on that transfer edge. All outputs are registered.

Top module: `csm_timer`

## Requirements
- R1: `req_ready` is high only when idle. It drops in the cycle after a transfer and rises again two cycles after the data-valid cycle, that is, after one recovery cycle.
- R2: A synchronous active-high `rst` drives `cs_o`, `oe_o`, `we_o` and `dval_o` low and `req_ready` high from the next edge. This holds even in the middle of an access.
- R3: Number the cycles after the transfer edge as 1, 2, and so on. `bus_addr` holds the captured address from cycle 1. `cs_o` first rises in cycle 1+S, where S = (`cfg_acs` != 0) + `cfg_trlx`.
- R4: When `cfg_seta`=0, W = `cfg_scy`, or 2×`cfg_scy` when `cfg_trlx`=1 (at most 30). `cs_o` stays high for W+1 cycles, and `dval_o` pulses in the last of them.
- R5: When `cfg_seta`=0, an `ext_ack` sampled at a select-active edge where at least 2 wait cycles remain makes the next cycle the last one. An `ext_ack` sampled later than that has no effect.
- R6: When `cfg_seta`=1, `cfg_scy` is ignored. The first `ext_ack` sampled at the end of the second select-active cycle or any later one makes the next cycle the last. An acknowledge in the first select cycle is ignored, so every access has at least three select cycles.
- R7: On reads, `oe_o` rises one cycle after `cs_o` rises and falls together with `cs_o`. When `cs_o` lasts only one cycle, `oe_o` is high for the single cycle after it. `oe_o` is never high on writes.
- R8: On writes, `we_o` equals the captured byte enables in every select-active cycle and is zero in all other cycles. On reads it is always zero.
- R9: On a write with both `cfg_trlx` and `cfg_csnt` set and more than one select cycle, `we_o` is already zero in the data-valid cycle. If `cfg_acs` is also nonzero, `cs_o` is low in that cycle too. The data-valid timing itself does not change.
- R10: `dval_o` is high for exactly one cycle per access. Changing the option inputs after the transfer edge has no effect on the access already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | AW | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | NBE | Byte enables for writes |
| cfg_acs | input | 2 | Address-to-select setup option, nonzero adds one cycle |
| cfg_csnt | input | 1 | Early negation of strobes and select on writes |
| cfg_trlx | input | 1 | Relaxed timing: one more setup cycle and doubled wait count |
| cfg_scy | input | SCY_W | Wait-state count |
| cfg_seta | input | 1 | 1 = end the access on the external acknowledge |
| ext_ack | input | 1 | External transfer acknowledge |
| bus_addr | output | AW | Address held toward memory |
| cs_o | output | 1 | Chip select, active high |
| oe_o | output | 1 | Output enable, active high |
| we_o | output | NBE | Byte write strobes, active high |
| dval_o | output | 1 | Data-valid pulse that ends the access |

## Verification
The assertions rely on the requester never resetting in ways other than through `rst`. In external-acknowledge mode they assume that an acknowledge eventually arrives; the bench always supplies one in the second select cycle or later. Apart from that, they assume only that the option inputs are meaningful on the transfer edge. The bench changes the options in the middle of one access on purpose, to show they are held. It drives every input at falling edges, holds `ext_ack` high for one cycle at chosen positions, and never offers a request while a reset is being applied.

// File: rtl/csm_pkg.sv
package csm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_ACT   = 2'd2,
    ST_RECOV = 2'd3
  } csm_state_t;
endpackage

// File: rtl/csm_req_latch.sv
module csm_req_latch #(
  parameter int AW    = 24,
  parameter int NBE   = 4,
  parameter int SCY_W = 4,
  localparam int CNT_W = SCY_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [AW-1:0]    in_addr,
  input  logic             in_write,
  input  logic [NBE-1:0]   in_be,
  input  logic [1:0]       in_acs,
  input  logic             in_csnt,
  input  logic             in_trlx,
  input  logic [SCY_W-1:0] in_scy,
  input  logic             in_seta,
  output logic [AW-1:0]    hold_addr,
  output logic             eff_write,
  output logic [NBE-1:0]   eff_be,
  output logic             eff_acs_nz,
  output logic             eff_csnt,
  output logic             eff_trlx,
  output logic             eff_seta,
  output logic [CNT_W-1:0] eff_wait,
  output logic [1:0]       setup_now
);
  logic             h_write, h_acs_nz, h_csnt, h_trlx, h_seta;
  logic [NBE-1:0]   h_be;
  logic [CNT_W-1:0] h_wait;
  logic [CNT_W-1:0] raw_wait;
  logic             raw_acs_nz;

  // relaxed mode doubles the wait count
  assign raw_wait   = in_trlx ? {in_scy, 1'b0} : {1'b0, in_scy};
  assign raw_acs_nz = (in_acs != 2'b00);
  assign setup_now  = {1'b0, raw_acs_nz} + {1'b0, in_trlx};

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_addr <= '0;
      h_write   <= 1'b0;
      h_be      <= '0;
      h_acs_nz  <= 1'b0;
      h_csnt    <= 1'b0;
      h_trlx    <= 1'b0;
      h_seta    <= 1'b0;
      h_wait    <= '0;
    end else if (accept) begin
      hold_addr <= in_addr;
      h_write   <= in_write;
      h_be      <= in_be;
      h_acs_nz  <= raw_acs_nz;
      h_csnt    <= in_csnt;
      h_trlx    <= in_trlx;
      h_seta    <= in_seta;
      h_wait    <= raw_wait;
    end
  end

  // on the transfer edge the held copy is not yet loaded: forward the inputs
  assign eff_write  = accept ? in_write   : h_write;
  assign eff_be     = accept ? in_be      : h_be;
  assign eff_acs_nz = accept ? raw_acs_nz : h_acs_nz;
  assign eff_csnt   = accept ? in_csnt    : h_csnt;
  assign eff_trlx   = accept ? in_trlx    : h_trlx;
  assign eff_seta   = accept ? in_seta    : h_seta;
  assign eff_wait   = accept ? raw_wait   : h_wait;
endmodule

// File: rtl/csm_seq.sv
module csm_seq
  import csm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [1:0] setup_now,
  input  logic       fin_q,
  output csm_state_t st,
  output csm_state_t ns,
  output logic       accept,
  output logic       req_ready
);
  logic [1:0] scnt, scnt_n;

  assign accept = req_valid && req_ready;

  always_comb begin
    ns     = st;
    scnt_n = scnt;
    unique case (st)
      ST_IDLE: begin
        if (accept) begin
          if (setup_now == 2'd0) begin
            ns = ST_ACT;
          end else begin
            ns     = ST_SETUP;
            scnt_n = setup_now - 2'd1;
          end
        end
      end
      ST_SETUP: begin
        if (scnt == 2'd0) ns = ST_ACT;
        else scnt_n = scnt - 2'd1;
      end
      ST_ACT:   if (fin_q) ns = ST_RECOV;
      ST_RECOV: ns = ST_IDLE;
      default:  ns = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      scnt      <= 2'd0;
      req_ready <= 1'b1;
    end else begin
      st        <= ns;
      scnt      <= scnt_n;
      req_ready <= (ns == ST_IDLE);
    end
  end
endmodule

// File: rtl/csm_wait_ctr.sv
module csm_wait_ctr
  import csm_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  csm_state_t       st,
  input  csm_state_t       ns,
  input  logic [CNT_W-1:0] eff_wait,
  input  logic             eff_seta,
  input  logic             ext_ack,
  output logic             fin_q,
  output logic             fin_n,
  output logic             first_n
);
  localparam logic [CNT_W-1:0] EARLY_MIN = CNT_W'(2);

  logic [CNT_W-1:0] cnt, cnt_n;
  logic             first_q;
  logic             enter;

  assign enter = (ns == ST_ACT) && (st != ST_ACT);

  always_comb begin
    cnt_n   = cnt;
    fin_n   = 1'b0;
    first_n = 1'b0;
    if (enter) begin
      cnt_n   = eff_wait;
      first_n = 1'b1;
      fin_n   = !eff_seta && (eff_wait == '0);
    end else if (st == ST_ACT && ns == ST_ACT) begin
      if (eff_seta) begin
        // acknowledge counts only from the second select cycle
        fin_n = ext_ack && !first_q;
      end else begin
        if (ext_ack && cnt >= EARLY_MIN) cnt_n = '0;
        else cnt_n = cnt - CNT_W'(1);
        fin_n = (cnt_n == '0);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      fin_q   <= 1'b0;
      first_q <= 1'b0;
    end else begin
      cnt     <= cnt_n;
      fin_q   <= fin_n;
      first_q <= first_n;
    end
  end
endmodule

// File: rtl/csm_strobe_gen.sv
module csm_strobe_gen
  import csm_pkg::*;
#(
  parameter int NBE = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  csm_state_t     ns,
  input  logic           fin_n,
  input  logic           first_n,
  input  logic           eff_write,
  input  logic [NBE-1:0] eff_be,
  input  logic           eff_acs_nz,
  input  logic           eff_csnt,
  input  logic           eff_trlx,
  output logic           cs_o,
  output logic           oe_o,
  output logic [NBE-1:0] we_o,
  output logic           dval_o
);
  logic           act_n, early, cs_d, oe_d, dval_d;
  logic [NBE-1:0] we_d;

  assign act_n  = (ns == ST_ACT);
  // negation one cycle early, only when the select lasts more than one cycle
  assign early  = eff_trlx && eff_csnt && eff_write && fin_n && !first_n;
  assign cs_d   = act_n && !(early && eff_acs_nz);
  assign we_d   = (act_n && eff_write && !early) ? eff_be : '0;
  assign oe_d   = !eff_write &&
                  ((act_n && !first_n) || (ns == ST_RECOV && !oe_o));
  assign dval_d = act_n && fin_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_o   <= 1'b0;
      oe_o   <= 1'b0;
      we_o   <= '0;
      dval_o <= 1'b0;
    end else begin
      cs_o   <= cs_d;
      oe_o   <= oe_d;
      we_o   <= we_d;
      dval_o <= dval_d;
    end
  end
endmodule

// File: rtl/csm_timer.sv
module csm_timer
  import csm_pkg::*;
#(
  parameter int AW    = 24,
  parameter int NBE   = 4,
  parameter int SCY_W = 4,
  localparam int CNT_W = SCY_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic             req_write,
  input  logic [NBE-1:0]   req_be,
  input  logic [1:0]       cfg_acs,
  input  logic             cfg_csnt,
  input  logic             cfg_trlx,
  input  logic [SCY_W-1:0] cfg_scy,
  input  logic             cfg_seta,
  input  logic             ext_ack,
  output logic [AW-1:0]    bus_addr,
  output logic             cs_o,
  output logic             oe_o,
  output logic [NBE-1:0]   we_o,
  output logic             dval_o
);
  csm_state_t       st, ns;
  logic             accept, fin_q, fin_n, first_n;
  logic             eff_write, eff_acs_nz, eff_csnt, eff_trlx, eff_seta;
  logic [NBE-1:0]   eff_be;
  logic [CNT_W-1:0] eff_wait;
  logic [1:0]       setup_now;

  csm_req_latch #(.AW(AW), .NBE(NBE), .SCY_W(SCY_W)) u_latch (
    .clk(clk), .rst(rst), .accept(accept),
    .in_addr(req_addr), .in_write(req_write), .in_be(req_be),
    .in_acs(cfg_acs), .in_csnt(cfg_csnt), .in_trlx(cfg_trlx),
    .in_scy(cfg_scy), .in_seta(cfg_seta),
    .hold_addr(bus_addr), .eff_write(eff_write), .eff_be(eff_be),
    .eff_acs_nz(eff_acs_nz), .eff_csnt(eff_csnt), .eff_trlx(eff_trlx),
    .eff_seta(eff_seta), .eff_wait(eff_wait), .setup_now(setup_now)
  );

  csm_seq u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .setup_now(setup_now),
    .fin_q(fin_q), .st(st), .ns(ns), .accept(accept), .req_ready(req_ready)
  );

  csm_wait_ctr #(.CNT_W(CNT_W)) u_wait (
    .clk(clk), .rst(rst), .st(st), .ns(ns), .eff_wait(eff_wait),
    .eff_seta(eff_seta), .ext_ack(ext_ack),
    .fin_q(fin_q), .fin_n(fin_n), .first_n(first_n)
  );

  csm_strobe_gen #(.NBE(NBE)) u_strobe (
    .clk(clk), .rst(rst), .ns(ns), .fin_n(fin_n), .first_n(first_n),
    .eff_write(eff_write), .eff_be(eff_be), .eff_acs_nz(eff_acs_nz),
    .eff_csnt(eff_csnt), .eff_trlx(eff_trlx),
    .cs_o(cs_o), .oe_o(oe_o), .we_o(we_o), .dval_o(dval_o)
  );
endmodule

// File: rtl/csm_timer_chk.sv
module csm_timer_chk #(
  parameter int NBE = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           req_valid,
  input logic           req_ready,
  input logic           cs_o,
  input logic           oe_o,
  input logic [NBE-1:0] we_o,
  input logic           dval_o
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!cs_o && !oe_o && we_o == '0 && !dval_o));

  p_accept_busy_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  p_oe_we_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(oe_o && (we_o != '0)));

  p_oe_after_cs_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_o) |-> $past(cs_o));

  p_we_in_cs_r8: assert property (@(posedge clk) disable iff (rst)
    (we_o != '0) |-> cs_o);

  p_dval_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    dval_o |=> !dval_o);

  p_dval_end_r4: assert property (@(posedge clk) disable iff (rst)
    dval_o |=> !cs_o);
endmodule

bind csm_timer csm_timer_chk #(.NBE(NBE)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .cs_o(cs_o), .oe_o(oe_o), .we_o(we_o), .dval_o(dval_o)
);

// File: tb/sim_csm_timer.sv
`timescale 1ns/1ps
module sim_csm_timer;
  localparam int AW = 24;
  localparam int NBE = 4;
  localparam int SCY_W = 4;
  localparam int TMAX = 48;
  localparam time PER = 20ns;

  typedef struct packed {
    logic [1:0] acs;
    logic       csnt;
    logic       trlx;
    logic [3:0] scy;
    logic       seta;
    logic       wr;
    logic [3:0] be;
    logic [5:0] ack_a;
    logic [5:0] ack_b;
    logic [5:0] csf;
    logic [5:0] csl;
    logic [5:0] dv;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{2'd0,1'b0,1'b0,4'd0, 1'b0,1'b0,4'hF,6'd0,6'd0,6'd1,6'd1,6'd1},
    '{2'd2,1'b0,1'b0,4'd3, 1'b0,1'b0,4'hF,6'd0,6'd0,6'd2,6'd5,6'd5},
    '{2'd3,1'b0,1'b1,4'd2, 1'b0,1'b1,4'h5,6'd0,6'd0,6'd3,6'd7,6'd7},
    '{2'd2,1'b1,1'b1,4'd1, 1'b0,1'b1,4'hF,6'd0,6'd0,6'd3,6'd4,6'd5},
    '{2'd0,1'b1,1'b1,4'd1, 1'b0,1'b1,4'hF,6'd0,6'd0,6'd2,6'd4,6'd4},
    '{2'd0,1'b0,1'b0,4'd6, 1'b0,1'b0,4'hF,6'd3,6'd0,6'd1,6'd4,6'd4},
    '{2'd0,1'b0,1'b0,4'd3, 1'b0,1'b0,4'hF,6'd3,6'd0,6'd1,6'd4,6'd4},
    '{2'd0,1'b0,1'b1,4'd9, 1'b1,1'b1,4'h3,6'd3,6'd0,6'd2,6'd4,6'd4},
    '{2'd0,1'b0,1'b1,4'd9, 1'b1,1'b0,4'hF,6'd2,6'd5,6'd2,6'd6,6'd6},
    '{2'd0,1'b0,1'b1,4'd15,1'b0,1'b0,4'hF,6'd0,6'd0,6'd2,6'd32,6'd32},
    '{2'd2,1'b1,1'b0,4'd2, 1'b0,1'b1,4'hF,6'd0,6'd0,6'd2,6'd4,6'd4},
    '{2'd0,1'b0,1'b0,4'd0, 1'b1,1'b1,4'hC,6'd2,6'd0,6'd1,6'd3,6'd3}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [AW-1:0]    req_addr = '0;
  logic             req_write = 1'b0;
  logic [NBE-1:0]   req_be = '0;
  logic [1:0]       cfg_acs = '0;
  logic             cfg_csnt = 1'b0;
  logic             cfg_trlx = 1'b0;
  logic [SCY_W-1:0] cfg_scy = '0;
  logic             cfg_seta = 1'b0;
  logic             ext_ack = 1'b0;
  logic [AW-1:0]    bus_addr;
  logic             cs_o, oe_o, dval_o;
  logic [NBE-1:0]   we_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(PER/2) clk = ~clk;

  csm_timer #(.AW(AW), .NBE(NBE), .SCY_W(SCY_W)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_be(req_be),
    .cfg_acs(cfg_acs), .cfg_csnt(cfg_csnt), .cfg_trlx(cfg_trlx),
    .cfg_scy(cfg_scy), .cfg_seta(cfg_seta), .ext_ack(ext_ack),
    .bus_addr(bus_addr), .cs_o(cs_o), .oe_o(oe_o), .we_o(we_o),
    .dval_o(dval_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act,
                     input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one access; scramble changes the options right after the transfer edge
  task automatic run_vec(input vec_t v, input bit scramble, input int idx);
    logic [63:0] a_cs, a_oe, a_we, a_dv, e_cs, e_oe, e_we, e_dv;
    int t, t_end, we_last;
    logic [AW-1:0] addr;
    a_cs = '0; a_oe = '0; a_we = '0; a_dv = '0;
    e_cs = '0; e_oe = '0; e_we = '0; e_dv = '0;
    addr = AW'(24'h1000 + idx * 16'h0123);
    @(negedge clk);
    req_addr = addr; req_write = v.wr; req_be = v.be;
    cfg_acs = v.acs; cfg_csnt = v.csnt; cfg_trlx = v.trlx;
    cfg_scy = v.scy; cfg_seta = v.seta; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (scramble) begin
      cfg_scy = 4'd15; cfg_seta = 1'b1; cfg_trlx = 1'b1; cfg_acs = 2'd3;
      req_write = ~v.wr; req_be = ~v.be; req_addr = ~addr;
    end
    t_end = 0;
    for (int k = 1; k < TMAX; k++) begin
      t = k;
      if (cs_o) a_cs[t] = 1'b1;
      if (oe_o) a_oe[t] = 1'b1;
      if (we_o != '0) a_we[t] = 1'b1;
      if (we_o != '0 && we_o != v.be) a_we[63] = 1'b1;
      if (dval_o) a_dv[t] = 1'b1;
      if (t == 1) chk(bus_addr == addr, "R3 address hold", bus_addr, addr);
      if (req_ready) begin t_end = t; break; end
      ext_ack = (t == int'(v.ack_a) && v.ack_a != 0) ||
                (t == int'(v.ack_b) && v.ack_b != 0);
      @(negedge clk);
    end
    ext_ack = 1'b0;
    for (int k = int'(v.csf); k <= int'(v.csl); k++) e_cs[k] = 1'b1;
    e_dv[v.dv] = 1'b1;
    we_last = (v.trlx && v.csnt && v.dv > v.csf) ? int'(v.dv) - 1 : int'(v.dv);
    if (v.wr) for (int k = int'(v.csf); k <= we_last; k++) e_we[k] = 1'b1;
    if (!v.wr) begin
      if (v.csl > v.csf) for (int k = int'(v.csf) + 1; k <= int'(v.csl); k++) e_oe[k] = 1'b1;
      else e_oe[v.csf + 6'd1] = 1'b1;
    end
    chk(a_cs == e_cs, $sformatf("R3 R4 R9 cs vec%0d", idx), a_cs, e_cs);
    chk(a_we == e_we, $sformatf("R8 R9 we vec%0d", idx), a_we, e_we);
    chk(a_oe == e_oe, $sformatf("R7 oe vec%0d", idx), a_oe, e_oe);
    chk(a_dv == e_dv, $sformatf("R4 R5 R6 R10 dval vec%0d", idx), a_dv, e_dv);
    chk(t_end == int'(v.dv) + 2, $sformatf("R1 ready return vec%0d", idx),
        t_end, v.dv + 6'd2);
  endtask

  initial begin
    vec_t d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R2: outputs after reset
    chk(!cs_o && !oe_o && !dval_o, "R2 reset cs/oe/dval", {cs_o, oe_o, dval_o}, 0);
    chk(we_o == '0, "R2 reset we", we_o, 0);
    chk(req_ready, "R2 reset ready", req_ready, 1);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) run_vec(VEC[i], 1'b0, i);

    // R10: options changed after transfer are ignored (scy 2, read, internal)
    d = '{2'd0,1'b0,1'b0,4'd2,1'b0,1'b0,4'hF,6'd0,6'd0,6'd1,6'd3,6'd3};
    run_vec(d, 1'b1, 20);
    // R10 on a write with early negation, options scrambled
    d = '{2'd2,1'b1,1'b1,4'd2,1'b0,1'b1,4'h9,6'd0,6'd0,6'd3,6'd6,6'd7};
    run_vec(d, 1'b1, 21);
    // R5: ack with exactly two cycles left still ends early (scy 4, ack at t=3)
    d = '{2'd0,1'b0,1'b0,4'd4,1'b0,1'b0,4'hF,6'd3,6'd0,6'd1,6'd4,6'd4};
    run_vec(d, 1'b0, 22);

    // R2: reset in the middle of an access
    @(negedge clk);
    cfg_acs = 2'd0; cfg_trlx = 1'b0; cfg_csnt = 1'b0; cfg_seta = 1'b0;
    cfg_scy = 4'd10; req_write = 1'b1; req_be = 4'hF; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(cs_o && we_o == 4'hF, "R8 write strobes active before reset", {cs_o, we_o}, 5'h1F);
    rst = 1'b1;
    @(negedge clk);
    chk(!cs_o && we_o == '0 && !oe_o && !dval_o, "R2 mid-access reset outputs",
        {cs_o, oe_o, dval_o, we_o}, 0);
    chk(req_ready, "R2 mid-access reset ready", req_ready, 1);
    rst = 1'b0;

    // R1: request held high is taken once, back-pressured while busy
    @(negedge clk);
    cfg_scy = 4'd1; req_write = 1'b0; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(!req_ready, "R1 busy after transfer", req_ready, 0);
    repeat (3) @(negedge clk);
    chk(req_ready, "R1 ready after recovery", req_ready, 1);
    req_valid = 1'b0;
    repeat (6) @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PER * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule